// File: doc/BRIEF.md
# Double-Buffered Event Store with Recording Freeze

This block holds 32-bit hit words between a fast producer and a slower reader. It has two memory banks of equal depth. One bank takes new words, and the other is handed to the reader. The producer may push one word every clock cycle in bursts. The reader empties its bank at its own pace, and its rate sets the sustained average.

The roles of the banks change when the recording bank holds at least the almost-full threshold of words and the reader's bank has been fully emptied. The filled bank then goes to the reader along with its word count, and recording moves to the other bank. If the reader is still busy, recording carries on until the bank is truly full and then freezes. While frozen, arriving words are refused and counted as lost. Recording resumes once the reader finishes its bank.

A saturating lost-word counter and a sticky freeze flag report losses. A status-clear input resets both.

Top module: `pp_event_buf`

## Requirements
- R1: After reset:
  - bank 0 records;
  - `wr_ready` is 1;
  - `rd_avail` is 0;
  - `lost_count` is 0;
  - `freeze_seen` is 0.
- R2: While `wr_ready` is 1, every cycle with `wr_valid` high stores `wr_data`. A burst of back-to-back writes is accepted without gaps.
- R3: A swap happens on the clock edge where a write brings the recording bank's count to at least `AFULL`, provided the reader has no bank. After that edge:
  - `rd_avail` is 1;
  - `rd_count` equals the number of stored words;
  - `rec_bank` has toggled.
- R4: If the reader still holds a bank, recording continues up to `DEPTH` words. `wr_ready` then drops to 0, because the block is frozen.
- R5: Each `rd_en` pulse with `rd_avail` high moves to the next word. The words appear on `rd_data` in write order. `rd_last` is 1 during the pop of the final word, and `rd_avail` is 0 after that pop.
- R6: When the reader finishes a bank while recording is frozen, the swap happens on the next clock edge. After it, `wr_ready` is 1 and `rd_count` equals `DEPTH`.
- R7: Each cycle with `wr_valid` high and `wr_ready` low adds one to `lost_count`. The count saturates at 2^`LW`-1.
- R8: `freeze_seen` sets when `wr_ready` is 0 and stays set until `clr_status`. `clr_status` sets both `freeze_seen` and `lost_count` to 0, unless a word is dropped in the same cycle. In that case the counter becomes 1 and the flag becomes 1.
- R9: `rd_en` while `rd_avail` is 0 has no effect on the stored words or on their read order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Producer offers a word |
| wr_data | input | 32 | Hit word |
| wr_ready | output | 1 | Word accepted this cycle (low only while frozen) |
| rd_en | input | 1 | Reader pops the current word |
| rd_data | output | 32 | Current word of the reader's bank |
| rd_avail | output | 1 | Reader holds a bank with words left |
| rd_count | output | $clog2(DEPTH+1) | Word count of the bank handed to the reader |
| rd_last | output | 1 | This pop empties the reader's bank |
| rec_bank | output | 1 | Index of the recording bank |
| clr_status | input | 1 | Clear lost count and freeze flag |
| lost_count | output | LW | Saturating count of refused words |
| freeze_seen | output | 1 | Sticky: recording was frozen |

## Verification
Writes, swaps and pops all take effect on the clock edge after the inputs are driven.

- **Swap:** `rd_avail`, `rd_count` and `rec_bank` change one edge after the write that reaches the threshold.
- **Freeze release:** the swap comes one edge after the final pop, so `rd_avail` reads 0 for exactly one cycle in between.
- **Read path:** `rd_data` and `rd_last` are combinational from the read pointer, so they are compared in the same cycle that `rd_en` is driven.
- **Loss reporting:** the lost counter and the flag are checked one edge after the dropped words.

All inputs are driven on falling edges, and all outputs are sampled on falling edges.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/pp_bank.sv
module pp_bank #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  pp_pkg::word_t     wdata,
  input  logic [AW-1:0]     raddr,
  output pp_pkg::word_t     rdata
);
  pp_pkg::word_t mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/pp_rec_ctl.sv
module pp_rec_ctl #(
  parameter int DEPTH = 16,
  parameter int AFULL = 12,
  parameter int LW    = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic          clr_status,
  input  logic          rd_empty,
  output logic          wr_ready,
  output logic          wr_fire,
  output logic [AW-1:0] waddr,
  output logic          rec_bank,
  output logic          swap,
  output logic [CW-1:0] swap_count,
  output logic [LW-1:0] lost_count,
  output logic          freeze_seen
);
  localparam logic [LW-1:0] LMAX = {LW{1'b1}};

  logic [CW-1:0] wcnt_q, wcnt_d, wcnt_inc;
  logic          bank_q, bank_d;
  logic [LW-1:0] lost_q, lost_d;
  logic          frz_q, frz_d;
  logic          drop;

  always_comb begin
    wr_ready = (wcnt_q != CW'(DEPTH));
    wr_fire  = wr_valid && wr_ready;
    drop     = wr_valid && !wr_ready;
    wcnt_inc = wcnt_q + CW'(wr_fire);
    swap     = rd_empty && (wcnt_inc >= CW'(AFULL));
    wcnt_d   = swap ? '0 : wcnt_inc;
    bank_d   = swap ? !bank_q : bank_q;
    if (clr_status) begin
      lost_d = drop ? LW'(1) : '0;
      frz_d  = !wr_ready;
    end else begin
      lost_d = (drop && lost_q != LMAX) ? lost_q + LW'(1) : lost_q;
      frz_d  = frz_q || !wr_ready;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      bank_q <= 1'b0;
      lost_q <= '0;
      frz_q  <= 1'b0;
    end else begin
      wcnt_q <= wcnt_d;
      bank_q <= bank_d;
      lost_q <= lost_d;
      frz_q  <= frz_d;
    end
  end

  assign waddr       = wcnt_q[AW-1:0];
  assign rec_bank    = bank_q;
  assign swap_count  = wcnt_inc;
  assign lost_count  = lost_q;
  assign freeze_seen = frz_q;

  // R7
  lost_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !clr_status && lost_q != LMAX) |=> lost_q == $past(lost_q) + LW'(1));

  // R7
  lost_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_q == LMAX && !clr_status) |=> lost_q == LMAX);
endmodule

// File: rtl/pp_rd_ctl.sv
module pp_rd_ctl #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          swap,
  input  logic [CW-1:0] swap_count,
  input  logic          swap_bank,
  input  logic          rd_en,
  output logic          rd_avail,
  output logic [CW-1:0] rd_count,
  output logic          rd_bank,
  output logic [AW-1:0] raddr,
  output logic          rd_last
);
  logic          avail_q, avail_d;
  logic [CW-1:0] cnt_q, cnt_d, ptr_q, ptr_d;
  logic          bank_q, bank_d;
  logic          pop;

  always_comb begin
    pop     = rd_en && avail_q;
    rd_last = pop && (ptr_q + CW'(1) == cnt_q);
    avail_d = avail_q;
    cnt_d   = cnt_q;
    ptr_d   = ptr_q;
    bank_d  = bank_q;
    if (swap) begin
      avail_d = 1'b1;
      cnt_d   = swap_count;
      ptr_d   = '0;
      bank_d  = swap_bank;
    end else if (pop) begin
      if (rd_last) begin
        avail_d = 1'b0;
        ptr_d   = '0;
      end else begin
        ptr_d = ptr_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avail_q <= 1'b0;
      cnt_q   <= '0;
      ptr_q   <= '0;
      bank_q  <= 1'b1;
    end else begin
      avail_q <= avail_d;
      cnt_q   <= cnt_d;
      ptr_q   <= ptr_d;
      bank_q  <= bank_d;
    end
  end

  assign rd_avail = avail_q;
  assign rd_count = cnt_q;
  assign rd_bank  = bank_q;
  assign raddr    = ptr_q[AW-1:0];

  // R5
  last_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |=> !rd_avail);

  // R9
  idle_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !avail_q && !swap) |=> !rd_avail);
endmodule

// File: rtl/pp_event_buf.sv
module pp_event_buf #(
  parameter int DEPTH = 16,
  parameter int AFULL = 12,
  parameter int LW    = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [31:0]   wr_data,
  output logic          wr_ready,
  input  logic          rd_en,
  output logic [31:0]   rd_data,
  output logic          rd_avail,
  output logic [CW-1:0] rd_count,
  output logic          rd_last,
  output logic          rec_bank,
  input  logic          clr_status,
  output logic [LW-1:0] lost_count,
  output logic          freeze_seen
);
  logic          rst_m_q, rst_s_q;
  logic          wr_fire, swap, rd_bank;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] swap_count;
  pp_pkg::word_t bank_rdata [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  pp_rec_ctl #(.DEPTH(DEPTH), .AFULL(AFULL), .LW(LW)) rec_i (
    .clk(clk), .rst_n(rst_s_q), .wr_valid(wr_valid), .clr_status(clr_status),
    .rd_empty(!rd_avail), .wr_ready(wr_ready), .wr_fire(wr_fire), .waddr(waddr),
    .rec_bank(rec_bank), .swap(swap), .swap_count(swap_count),
    .lost_count(lost_count), .freeze_seen(freeze_seen)
  );

  pp_rd_ctl #(.DEPTH(DEPTH)) rd_i (
    .clk(clk), .rst_n(rst_s_q), .swap(swap), .swap_count(swap_count),
    .swap_bank(rec_bank), .rd_en(rd_en), .rd_avail(rd_avail),
    .rd_count(rd_count), .rd_bank(rd_bank), .raddr(raddr), .rd_last(rd_last)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    pp_bank #(.DEPTH(DEPTH)) bank_i (
      .clk(clk), .we(wr_fire && (rec_bank == b[0])), .waddr(waddr),
      .wdata(wr_data), .raddr(raddr), .rdata(bank_rdata[b])
    );
  end

  assign rd_data = bank_rdata[rd_bank];

  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_s_q)
    rd_avail |-> (rd_count >= CW'(AFULL) && rd_count <= CW'(DEPTH)));

  // R3
  swap_pair_chk: assert property (@(posedge clk) disable iff (!rst_s_q)
    (rec_bank != $past(rec_bank)) |-> $rose(rd_avail));

  // R6
  resume_chk: assert property (@(posedge clk) disable iff (!rst_s_q)
    (!wr_ready && !rd_avail) |=> (wr_ready && rd_avail));

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_s_q)
    (freeze_seen && !clr_status) |=> freeze_seen);
endmodule

// File: tb/pp_event_buf_tb_top.sv
module pp_event_buf_tb_top;
  localparam int DEPTH = 8;
  localparam int AFULL = 6;
  localparam int LW    = 3;
  localparam int CW    = $clog2(DEPTH+1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [31:0]   wr_data = '0;
  logic          wr_ready;
  logic          rd_en = 1'b0;
  logic [31:0]   rd_data;
  logic          rd_avail;
  logic [CW-1:0] rd_count;
  logic          rd_last;
  logic          rec_bank;
  logic          clr_status = 1'b0;
  logic [LW-1:0] lost_count;
  logic          freeze_seen;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_q [$];

  always #10 clk = !clk;

  pp_event_buf #(.DEPTH(DEPTH), .AFULL(AFULL), .LW(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_en(rd_en), .rd_data(rd_data), .rd_avail(rd_avail),
    .rd_count(rd_count), .rd_last(rd_last), .rec_bank(rec_bank),
    .clr_status(clr_status), .lost_count(lost_count), .freeze_seen(freeze_seen)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver: offers one word per call, back-to-back calls form a burst
  task automatic push(logic [31:0] d, logic exp_rdy, string req);
    wr_valid = 1'b1;
    wr_data  = d;
    chk(req, wr_ready, exp_rdy);
    if (wr_ready) exp_q.push_back(d);
    @(posedge clk); @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // monitor: pops one word and compares it with the scoreboard head
  task automatic pop(logic exp_last);
    logic [31:0] e;
    rd_en = 1'b1;
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hdead_beef;
    chk("R5 data", rd_data, e);
    chk("R5 last", rd_last, exp_last);
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 ready", wr_ready, 1);
    chk("R1 avail", rd_avail, 0);
    chk("R1 bank", rec_bank, 0);
    chk("R1 lost", lost_count, 0);
    chk("R1 frz", freeze_seen, 0);

    // R9 pops with no bank held are ignored
    rd_en = 1'b1;
    repeat (2) @(negedge clk);
    rd_en = 1'b0;
    chk("R9 avail", rd_avail, 0);

    // R2 burst of 5 stays below threshold
    for (int i = 0; i < 5; i++) push(32'h100 + i, 1, "R2 ready");
    chk("R3 no swap below", rd_avail, 0);
    push(32'h105, 1, "R2 ready");
    chk("R3 avail", rd_avail, 1);
    chk("R3 count", rd_count, 6);
    chk("R3 bank", rec_bank, 1);

    // R4 reader busy: fill bank 1 to DEPTH, then freeze
    for (int i = 0; i < 8; i++) push(32'h200 + i, 1, "R4 ready");
    chk("R4 frozen", wr_ready, 0);
    chk("R4 no swap", rec_bank, 1);
    for (int i = 0; i < 3; i++) push(32'hbad0 + i, 0, "R4 ready low");
    chk("R7 lost", lost_count, 3);
    chk("R8 frz", freeze_seen, 1);

    // R5 drain first bank, R9 word order intact
    for (int i = 0; i < 6; i++) pop(i == 5);
    chk("R5 avail drop", rd_avail, 0);
    chk("R6 still frozen", wr_ready, 0);
    @(posedge clk); @(negedge clk);
    chk("R6 avail", rd_avail, 1);
    chk("R6 count", rd_count, DEPTH);
    chk("R6 ready", wr_ready, 1);
    chk("R6 bank", rec_bank, 0);
    for (int i = 0; i < 8; i++) pop(i == 7);
    chk("R5 empty", rd_avail, 0);

    // R8 clear
    clr_status = 1'b1;
    @(posedge clk); @(negedge clk);
    clr_status = 1'b0;
    chk("R8 lost clr", lost_count, 0);
    chk("R8 frz clr", freeze_seen, 0);

    // R7 saturation
    for (int i = 0; i < 6; i++) push(32'h300 + i, 1, "R2 ready");
    chk("R3 swap2", rd_count, 6);
    for (int i = 0; i < 8; i++) push(32'h400 + i, 1, "R4 ready");
    for (int i = 0; i < 10; i++) push(32'hbee0 + i, 0, "R7 ready low");
    chk("R7 sat", lost_count, 7);

    // R8 clear with a drop in the same cycle
    wr_valid = 1'b1;
    clr_status = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_valid = 1'b0;
    clr_status = 1'b0;
    chk("R8 clr+drop lost", lost_count, 1);
    chk("R8 clr+drop frz", freeze_seen, 1);

    for (int i = 0; i < 6; i++) pop(i == 5);
    @(posedge clk); @(negedge clk);
    for (int i = 0; i < 8; i++) pop(i == 7);
    chk("R5 final empty", rd_avail, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule